// File: doc/BRIEF.md
# Bus Master Security Gate

This block sits between a bus-mastering device, such as a DMA engine, and the downstream memory bus. For each read or write it decides one of four outcomes. The transaction may be forwarded downstream marked secure, forwarded marked non-secure, blocked with an error response, or blocked as read-as-zero/write-ignored. The decision uses three inputs. The first is a static configuration that says whether the master is treated as non-secure and how blocked accesses answer. The second is a held interrupt-clear level. The third is a security attribution of the address, taken from a small parameterised table of exempt and secure address ranges.

Both sides use a valid/ready request channel and a valid-only response channel. Requests carry address, write flag, write data and a size code; responses carry read data and an error flag. Only one transaction is in flight at a time. A blocked transaction answers in the cycle after it is accepted and never reaches the downstream side. A registered, sticky level interrupt reports blocks that end in an error.

Top module: `secGate`

## Requirements
- R1: An address inside an exempt region is forwarded, with dnSecure = 1 when cfgNonSec is 0 and dnSecure = 0 when cfgNonSec is 1.
- R2: An address matching no region is forwarded with dnSecure = 0, whatever cfgNonSec and cfgSecResp are.
- R3: An address inside a secure region (and no exempt region) with cfgNonSec = 0 is forwarded with dnSecure = 1.
- R4: A secure-region address with cfgNonSec = 1 and cfgSecResp = 0 is blocked. A read answers upRdata = 0 with upRspErr = 0, a write answers upRspErr = 0, and no downstream request is made.
- R5: A secure-region address with cfgNonSec = 1 and cfgSecResp = 1 is blocked with upRspErr = 1, and no downstream request is made.
- R6: An error-type block (R5) accepted while irqClear is 0 sets irqOut high in the cycle after acceptance, which is the cycle of its response. irqOut then stays high until cleared.
- R7: irqClear high at a clock edge forces irqOut low from the next cycle on. While irqClear is held high, error-type blocks do not set irqOut.
- R8: Read-as-zero/write-ignored blocks (R4) and forwarded transactions never change irqOut.
- R9: After reset, irqOut = 0, upReqReady = 1, upRspValid = 0 and dnReqValid = 0.
- R10: A forwarded request keeps address, write flag, write data and size code unchanged. The size code is 0..3 for 1, 2, 4 or 8 bytes. The request is held stable while dnReqReady is low. The downstream read data and error flag are returned on upRdata/upRspErr in the cycle dnRspValid is high.
- R11: Regions are inclusive base..limit ranges. An exempt match takes priority over a secure match, so an exempt window inside a secure range is treated as exempt. The first address past a secure limit is non-secure.
- R12: At most one transaction is outstanding. upReqReady is high only when idle, and never while a downstream request is pending. A blocked transaction responds in the cycle after acceptance, and the gate is ready again in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgNonSec | input | 1 | 1: the master is treated as non-secure |
| cfgSecResp | input | 1 | 1: blocked accesses answer with error; 0: read-as-zero/write-ignored |
| irqClear | input | 1 | Level clear and suppression of the blocked-access interrupt |
| irqOut | output | 1 | Sticky registered interrupt for error-type blocks |
| upReqValid | input | 1 | Upstream request valid |
| upReqReady | output | 1 | Gate can accept a request |
| upAddr | input | AW | Request address |
| upWrite | input | 1 | 1 = write, 0 = read |
| upWdata | input | DW | Write data |
| upSize | input | 2 | Size code (0:1B, 1:2B, 2:4B, 3:8B) |
| upRspValid | output | 1 | Upstream response valid |
| upRdata | output | DW | Read data returned upstream |
| upRspErr | output | 1 | Error flag returned upstream |
| dnReqValid | output | 1 | Downstream request valid |
| dnReqReady | input | 1 | Downstream accepts request |
| dnAddr | output | AW | Forwarded address |
| dnWrite | output | 1 | Forwarded write flag |
| dnWdata | output | DW | Forwarded write data |
| dnSize | output | 2 | Forwarded size code |
| dnSecure | output | 1 | Security attribute of the forwarded request |
| dnRspValid | input | 1 | Downstream response valid |
| dnRdata | input | DW | Downstream read data |
| dnRspErr | input | 1 | Downstream error flag |

## Verification
The bench aims at the region edges. It uses an exempt window nested inside a secure range, where a gate that ignored exempt priority would block or mark secure. It also probes the first address past a secure limit, where a gate with an off-by-one compare would block a non-secure access. For the interrupt, it checks that a read-as-zero block leaves irqOut low, that irqOut stays sticky across later clean transfers, and that a held irqClear both clears and suppresses it. A gate that latched the wrong block type, or forgot suppression, shows up in the per-cycle interrupt comparison. Stalled downstream handshakes check that a forwarded request is held steady and that an error from downstream is carried back rather than dropped.

// File: rtl/secGatePkg.sv
package secGatePkg;

  typedef enum logic [1:0] {
    ATTR_NONSEC = 2'd0,
    ATTR_SECURE = 2'd1,
    ATTR_EXEMPT = 2'd2
  } attr_e;

  typedef enum logic [1:0] {
    ACT_FWD_NS  = 2'd0,
    ACT_FWD_SEC = 2'd1,
    ACT_BLK_RAZ = 2'd2,
    ACT_BLK_ERR = 2'd3
  } action_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch the upstream request this cycle
    logic fwdSecure;  // attribute for the captured request
    logic blkErr;     // captured request ends in an error block
    logic issueDn;    // present the request downstream
    logic passRsp;    // route the downstream response upstream
    logic blockRsp;   // answer locally for a blocked request
  } gateStrobe_t;

  function automatic action_e decideAction(attr_e attr, logic nonSec, logic secResp);
    action_e act;
    case (attr)
      ATTR_EXEMPT: act = nonSec ? ACT_FWD_NS : ACT_FWD_SEC;
      ATTR_SECURE: begin
        if (!nonSec)      act = ACT_FWD_SEC;
        else if (secResp) act = ACT_BLK_ERR;
        else              act = ACT_BLK_RAZ;
      end
      default:     act = ACT_FWD_NS;
    endcase
    return act;
  endfunction

endpackage

// File: rtl/secGateAttr.sv
module secGateAttr
  import secGatePkg::*;
#(
  parameter int AW         = 32,
  parameter int NUM_EXEMPT = 2,
  parameter int NUM_SECURE = 2,
  parameter logic [NUM_EXEMPT*AW-1:0] EXEMPT_BASE  = '0,
  parameter logic [NUM_EXEMPT*AW-1:0] EXEMPT_LIMIT = '0,
  parameter logic [NUM_SECURE*AW-1:0] SECURE_BASE  = '0,
  parameter logic [NUM_SECURE*AW-1:0] SECURE_LIMIT = '0
) (
  input  logic [AW-1:0] addr,
  output attr_e         attr
);

  logic [NUM_EXEMPT-1:0] exemptHit;
  logic [NUM_SECURE-1:0] secureHit;

  for (genvar e = 0; e < NUM_EXEMPT; e++) begin : g_exempt
    localparam logic [AW-1:0] BASE  = EXEMPT_BASE[e*AW +: AW];
    localparam logic [AW-1:0] LIMIT = EXEMPT_LIMIT[e*AW +: AW];
    assign exemptHit[e] = (addr >= BASE) && (addr <= LIMIT);
  end

  for (genvar s = 0; s < NUM_SECURE; s++) begin : g_secure
    localparam logic [AW-1:0] BASE  = SECURE_BASE[s*AW +: AW];
    localparam logic [AW-1:0] LIMIT = SECURE_LIMIT[s*AW +: AW];
    assign secureHit[s] = (addr >= BASE) && (addr <= LIMIT);
  end

  // Exempt windows override secure ranges
  always_comb begin
    if (|exemptHit)      attr = ATTR_EXEMPT;
    else if (|secureHit) attr = ATTR_SECURE;
    else                 attr = ATTR_NONSEC;
  end

endmodule

// File: rtl/secGateCtrl.sv
module secGateCtrl
  import secGatePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgNonSec,
  input  logic        cfgSecResp,
  input  logic        irqClear,
  input  logic        upReqValid,
  input  logic        dnReqReady,
  input  logic        dnRspValid,
  input  attr_e       attr,
  output logic        upReqReady,
  output gateStrobe_t strobe,
  output logic        irqOut
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_BLOCK = 2'd3
  } state_e;

  state_e  state, stateNext;
  action_e action;
  logic    accept;
  logic    irqStatus;

  assign action     = decideAction(attr, cfgNonSec, cfgSecResp);
  assign upReqReady = (state == ST_IDLE);
  assign accept     = upReqValid && upReqReady;

  always_comb begin
    strobe           = '0;
    strobe.capture   = accept;
    strobe.fwdSecure = (action == ACT_FWD_SEC);
    strobe.blkErr    = (action == ACT_BLK_ERR);
    strobe.issueDn   = (state == ST_ISSUE);
    strobe.passRsp   = (state == ST_WAIT);
    strobe.blockRsp  = (state == ST_BLOCK);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          if (action == ACT_BLK_ERR || action == ACT_BLK_RAZ) stateNext = ST_BLOCK;
          else                                                stateNext = ST_ISSUE;
        end
      end
      ST_ISSUE: if (dnReqReady) stateNext = ST_WAIT;
      ST_WAIT:  if (dnRspValid) stateNext = ST_IDLE;
      ST_BLOCK: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // Sticky interrupt: clear wins, held clear suppresses new sets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   irqStatus <= 1'b0;
    else if (irqClear)                           irqStatus <= 1'b0;
    else if (accept && action == ACT_BLK_ERR)    irqStatus <= 1'b1;
  end

  assign irqOut = irqStatus;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    irqClear |=> !irqOut); // R7

  AST_RAZ_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (accept && action == ACT_BLK_RAZ && !irqClear) |=> (irqOut == $past(irqOut))); // R8

  AST_BLOCK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BLOCK) |=> upReqReady); // R12

endmodule

// File: rtl/secGateData.sv
module secGateData
  import secGatePkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  gateStrobe_t   strobe,
  input  logic [AW-1:0] upAddr,
  input  logic          upWrite,
  input  logic [DW-1:0] upWdata,
  input  logic [1:0]    upSize,
  output logic          upRspValid,
  output logic [DW-1:0] upRdata,
  output logic          upRspErr,
  output logic          dnReqValid,
  input  logic          dnReqReady,
  output logic [AW-1:0] dnAddr,
  output logic          dnWrite,
  output logic [DW-1:0] dnWdata,
  output logic [1:0]    dnSize,
  output logic          dnSecure,
  input  logic          dnRspValid,
  input  logic [DW-1:0] dnRdata,
  input  logic          dnRspErr
);

  logic [AW-1:0] reqAddr;
  logic          reqWrite;
  logic [DW-1:0] reqWdata;
  logic [1:0]    reqSize;
  logic          reqSecure;
  logic          reqErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr   <= '0;
      reqWrite  <= 1'b0;
      reqWdata  <= '0;
      reqSize   <= '0;
      reqSecure <= 1'b0;
      reqErr    <= 1'b0;
    end else if (strobe.capture) begin
      reqAddr   <= upAddr;
      reqWrite  <= upWrite;
      reqWdata  <= upWdata;
      reqSize   <= upSize;
      reqSecure <= strobe.fwdSecure;
      reqErr    <= strobe.blkErr;
    end
  end

  assign dnReqValid = strobe.issueDn;
  assign dnAddr     = reqAddr;
  assign dnWrite    = reqWrite;
  assign dnWdata    = reqWdata;
  assign dnSize     = reqSize;
  assign dnSecure   = reqSecure;

  always_comb begin
    upRspValid = 1'b0;
    upRdata    = '0;
    upRspErr   = 1'b0;
    if (strobe.blockRsp) begin
      upRspValid = 1'b1;
      upRspErr   = reqErr;
    end else if (strobe.passRsp && dnRspValid) begin
      upRspValid = 1'b1;
      upRdata    = dnRdata;
      upRspErr   = dnRspErr;
    end
  end

  AST_HOLD_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    (dnReqValid && !dnReqReady) |=> (dnReqValid && $stable(dnAddr) && $stable(dnWdata)
                                     && $stable(dnSecure) && $stable(dnSize))); // R10

  AST_NO_DN_ON_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.blockRsp |-> !dnReqValid); // R5

endmodule

// File: rtl/secGate.sv
module secGate
  import secGatePkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int NUM_EXEMPT = 2,
  parameter int NUM_SECURE = 2,
  parameter logic [NUM_EXEMPT*AW-1:0] EXEMPT_BASE  = {32'h1000_0000, 32'h4000_0000},
  parameter logic [NUM_EXEMPT*AW-1:0] EXEMPT_LIMIT = {32'h1000_00FF, 32'h4000_FFFF},
  parameter logic [NUM_SECURE*AW-1:0] SECURE_BASE  = {32'h3000_0000, 32'h1000_0000},
  parameter logic [NUM_SECURE*AW-1:0] SECURE_LIMIT = {32'h3000_FFFF, 32'h1FFF_FFFF}
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgNonSec,
  input  logic          cfgSecResp,
  input  logic          irqClear,
  output logic          irqOut,
  input  logic          upReqValid,
  output logic          upReqReady,
  input  logic [AW-1:0] upAddr,
  input  logic          upWrite,
  input  logic [DW-1:0] upWdata,
  input  logic [1:0]    upSize,
  output logic          upRspValid,
  output logic [DW-1:0] upRdata,
  output logic          upRspErr,
  output logic          dnReqValid,
  input  logic          dnReqReady,
  output logic [AW-1:0] dnAddr,
  output logic          dnWrite,
  output logic [DW-1:0] dnWdata,
  output logic [1:0]    dnSize,
  output logic          dnSecure,
  input  logic          dnRspValid,
  input  logic [DW-1:0] dnRdata,
  input  logic          dnRspErr
);

  attr_e       addrAttr;
  gateStrobe_t strobe;

  secGateAttr #(
    .AW(AW), .NUM_EXEMPT(NUM_EXEMPT), .NUM_SECURE(NUM_SECURE),
    .EXEMPT_BASE(EXEMPT_BASE), .EXEMPT_LIMIT(EXEMPT_LIMIT),
    .SECURE_BASE(SECURE_BASE), .SECURE_LIMIT(SECURE_LIMIT)
  ) u_attr (
    .addr (upAddr),
    .attr (addrAttr)
  );

  secGateCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgNonSec  (cfgNonSec),
    .cfgSecResp (cfgSecResp),
    .irqClear   (irqClear),
    .upReqValid (upReqValid),
    .dnReqReady (dnReqReady),
    .dnRspValid (dnRspValid),
    .attr       (addrAttr),
    .upReqReady (upReqReady),
    .strobe     (strobe),
    .irqOut     (irqOut)
  );

  secGateData #(.AW(AW), .DW(DW)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .upAddr     (upAddr),
    .upWrite    (upWrite),
    .upWdata    (upWdata),
    .upSize     (upSize),
    .upRspValid (upRspValid),
    .upRdata    (upRdata),
    .upRspErr   (upRspErr),
    .dnReqValid (dnReqValid),
    .dnReqReady (dnReqReady),
    .dnAddr     (dnAddr),
    .dnWrite    (dnWrite),
    .dnWdata    (dnWdata),
    .dnSize     (dnSize),
    .dnSecure   (dnSecure),
    .dnRspValid (dnRspValid),
    .dnRdata    (dnRdata),
    .dnRspErr   (dnRspErr)
  );

  AST_IRQ_WITH_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> (upRspValid && upRspErr)); // R6

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    upReqReady |-> !dnReqValid); // R12

endmodule

// File: tb/secGate_bench.sv
module secGate_bench;

  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgNonSec = 1'b0, cfgSecResp = 1'b0, irqClear = 1'b0;
  logic          irqOut;
  logic          upReqValid = 1'b0;
  logic          upReqReady;
  logic [AW-1:0] upAddr = '0;
  logic          upWrite = 1'b0;
  logic [DW-1:0] upWdata = '0;
  logic [1:0]    upSize = '0;
  logic          upRspValid;
  logic [DW-1:0] upRdata;
  logic          upRspErr;
  logic          dnReqValid;
  logic          dnReqReady = 1'b0;
  logic [AW-1:0] dnAddr;
  logic          dnWrite;
  logic [DW-1:0] dnWdata;
  logic [1:0]    dnSize;
  logic          dnSecure;
  logic          dnRspValid = 1'b0;
  logic [DW-1:0] dnRdata = '0;
  logic          dnRspErr = 1'b0;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit done = 0;
  bit modIrq = 0;

  always #4 clk = ~clk;  // 125 MHz

  secGate u_secGate (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural attribution: 0 non-secure, 1 secure, 2 exempt
  function automatic int attrOf(input logic [31:0] a);
    if ((a >= 32'h4000_0000 && a <= 32'h4000_FFFF) ||
        (a >= 32'h1000_0000 && a <= 32'h1000_00FF)) return 2;
    if ((a >= 32'h1000_0000 && a <= 32'h1FFF_FFFF) ||
        (a >= 32'h3000_0000 && a <= 32'h3000_FFFF)) return 1;
    return 0;
  endfunction

  // Per-cycle interrupt model and watchdog
  initial begin
    forever begin
      @(negedge clk);
      #3;
      cycles++;
      if (!done) begin
        chk(irqOut == modIrq, "R6/R7/R8", "irqOut per cycle", irqOut, modIrq);
        if (!rstN || irqClear) modIrq = 0;
        else if (upReqValid && upReqReady && attrOf(upAddr) == 1 && cfgNonSec && cfgSecResp)
          modIrq = 1;
      end
      if (cycles > 20000 && !done) begin
        done = 1;
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
        $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
        $finish;
      end
    end
  end

  task automatic doTxn(input logic [31:0] a, input logic w, input logic [63:0] wd,
                       input logic [1:0] sz, input int stall, input logic dErr,
                       input string req);
    int at = attrOf(a);
    bit blocked = (at == 1) && cfgNonSec;
    bit expSec  = (at == 1) ? 1'b1 : (at == 2) ? !cfgNonSec : 1'b0;
    logic [63:0] rd = {a, ~a};
    @(negedge clk); #1;
    chk(upReqReady == 1, "R12", "ready when idle", upReqReady, 1);
    upReqValid = 1; upAddr = a; upWrite = w; upWdata = wd; upSize = sz;
    @(negedge clk); #1;
    upReqValid = 0;
    if (blocked) begin
      chk(upRspValid == 1, "R12", "block responds next cycle", upRspValid, 1);
      chk(upRspErr == cfgSecResp, req, "block error flag", upRspErr, cfgSecResp);
      if (!w) chk(upRdata == 0, req, "blocked read data", upRdata, 0);
      chk(dnReqValid == 0, req, "no downstream on block", dnReqValid, 0);
      @(negedge clk); #1;
      chk(upRspValid == 0 && dnReqValid == 0 && upReqReady == 1, "R12",
          "idle after block", {upRspValid, dnReqValid, upReqReady}, 3'b001);
    end else begin
      chk(dnReqValid == 1, req, "forwarded", dnReqValid, 1);
      chk(dnSecure == expSec, req, "dnSecure", dnSecure, expSec);
      chk(dnAddr == a && dnSize == sz && dnWrite == w, "R10", "addr/size/write",
          dnAddr, a);
      if (w) chk(dnWdata == wd, "R10", "write data", dnWdata, wd);
      chk(upReqReady == 0, "R12", "busy while forwarding", upReqReady, 0);
      for (int i = 0; i < stall; i++) begin
        dnReqReady = 0;
        @(negedge clk); #1;
        chk(dnReqValid == 1 && dnAddr == a && dnSecure == expSec, "R10",
            "held during stall", dnAddr, a);
      end
      dnReqReady = 1;
      @(negedge clk); #1;
      dnReqReady = 0;
      chk(dnReqValid == 0 && upRspValid == 0, "R12", "waiting response",
          {dnReqValid, upRspValid}, 0);
      dnRspValid = 1; dnRdata = rd; dnRspErr = dErr;
      #1;
      chk(upRspValid == 1, "R10", "response passed", upRspValid, 1);
      chk(upRspErr == dErr, "R10", "error passed", upRspErr, dErr);
      if (!w) chk(upRdata == rd, "R10", "read data passed", upRdata, rd);
      @(negedge clk); #1;
      dnRspValid = 0; dnRspErr = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(irqOut == 0 && upReqReady == 1 && upRspValid == 0 && dnReqValid == 0,
        "R9", "reset state", {irqOut, upReqReady, upRspValid, dnReqValid}, 4'b0100);
    rstN = 1;

    // Secure master
    cfgNonSec = 0; cfgSecResp = 0;
    doTxn(32'h4000_0010, 0, 0, 2'd2, 0, 0, "R1");
    doTxn(32'h0000_1000, 0, 0, 2'd0, 1, 0, "R2");
    doTxn(32'h1800_0000, 0, 0, 2'd2, 2, 0, "R3");
    doTxn(32'h3000_0020, 1, 64'hDEAD_BEEF_0123_4567, 2'd3, 0, 0, "R3");
    doTxn(32'h2000_0000, 0, 0, 2'd1, 0, 1, "R10");

    // Non-secure master, read-as-zero blocks
    cfgNonSec = 1;
    doTxn(32'h4000_FFFF, 0, 0, 2'd2, 0, 0, "R1");
    doTxn(32'h1000_0080, 0, 0, 2'd2, 0, 0, "R11");
    doTxn(32'h0000_0040, 1, 64'h55, 2'd0, 0, 0, "R2");
    doTxn(32'h1000_0100, 0, 0, 2'd2, 0, 0, "R4");
    doTxn(32'h1FFF_FFFF, 1, 64'h77, 2'd3, 0, 0, "R4");
    doTxn(32'h2000_0000, 0, 0, 2'd2, 0, 0, "R11");

    // Error-type blocks and interrupt
    cfgSecResp = 1;
    doTxn(32'h3000_0000, 0, 0, 2'd2, 0, 0, "R5");
    doTxn(32'h0000_2000, 0, 0, 2'd2, 1, 0, "R8");
    doTxn(32'h1000_0200, 1, 64'h1, 2'd1, 0, 0, "R5");
    @(negedge clk); #1;
    chk(irqOut == 1, "R6", "irq sticky", irqOut, 1);
    irqClear = 1;
    doTxn(32'h1234_5678, 0, 0, 2'd2, 0, 0, "R7");
    doTxn(32'h3000_FFFF, 0, 0, 2'd2, 0, 0, "R7");
    #3;
    chk(irqOut == 0, "R7", "irq suppressed while clear held", irqOut, 0);
    @(negedge clk); #1;
    irqClear = 0;
    cfgSecResp = 0;
    doTxn(32'h1000_0300, 0, 0, 2'd2, 0, 0, "R8");
    cfgSecResp = 1;
    doTxn(32'h1000_0400, 0, 0, 2'd2, 0, 0, "R6");
    repeat (2) @(negedge clk);
    #3;
    chk(irqOut == 1, "R6", "irq after error block", irqOut, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule